// File: doc/BRIEF.md
# Single-Bus Processor Core with Hardwired Step Control

This block is a small processor core built around one shared internal bus. The eight general registers, the program counter, the instruction register, the memory address and memory data registers, the two scratch registers Y and Z, and a single adder all connect to that bus. In any one clock cycle exactly one source drives the bus and any number of registers may load from it. The ALU takes its A operand from a 2:1 selector that picks either Y or a fixed increment constant. Its B operand comes straight off the bus, and its sum is parked in Z before it can be driven back onto the bus.

Control is hardwired and has three parts. A step counter produces one-hot time slots. An opcode decoder raises exactly one of sixteen lines. An encoder forms every gating signal as an OR of time-slot terms and time-slot-and-opcode terms. Every instruction opens with the same three-step fetch and then runs a short execute sequence specific to its opcode. A terminating signal in the last step returns the step counter to the first slot. Memory is reached over a plain address/data port with one read strobe and one write strobe. The memory answers reads in the same cycle and has no wait states.

The core supports four instructions. An add-from-memory adds a word from memory into a register. A load reads a word from memory into a register. A store writes a register to memory. An unconditional PC-relative branch moves the program counter by a signed offset.

Top module: `sbus_core`

## Requirements
- R1: Synchronous reset clears PC, IR, MAR, MDR, Y, Z, every general register and the step counter to zero. While reset is held, both strobes, the address and the write data are 0. The first fetch after reset reads address 0 in the second cycle.
- R2: Every instruction starts with three fetch steps. The read strobe is high in step 2 with the address equal to the PC of the instruction, and the PC then advances by one word.
- R3: The instruction word is 16 bits. Bits 15:12 hold the opcode: 1 = add-from-memory, 2 = load, 3 = store, 4 = branch. Bits 11:9 hold register field A and bits 8:6 hold register field B. For a branch, bits 7:0 hold a two's-complement offset.
- R4: Add-from-memory takes 7 steps. It reads memory at the address held in register B during step 5, and writes A + that word (modulo 2^16) into register A.
- R5: Load takes 6 steps. It reads memory at the address held in register B during step 5, and writes the word into register A.
- R6: Store takes 6 steps. It asserts the write strobe in step 6 with the address taken from register B and the data taken from register A.
- R7: Branch takes 6 steps. It sets the PC to (address of the branch + 1) plus the sign-extended offset, and it touches no memory after the fetch.
- R8: Any other opcode ends after step 4 and changes no register other than PC and IR.
- R9: At most one source drives the internal bus in any cycle, and the read and write strobes are never high together.
- R10: The opcode decoder drives exactly one line. The terminating signal returns the step counter to step 1, and otherwise the counter advances by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address, taken from the memory address register |
| mem_wdata | output | 16 | Write data, taken from the memory data register |
| mem_rdata | input | 16 | Read data, which must be valid in the same cycle as the read strobe |
| mem_rd | output | 1 | Read strobe; the memory data register loads mem_rdata at the end of the cycle |
| mem_wr | output | 1 | Write strobe |

## Verification
A wrong step count or a missed terminating signal moves the next instruction's fetch read to a different cycle. That error therefore shows at the memory port within one instruction, as a read strobe in an unexpected cycle or at an unexpected address. A corrupted register, a wrong sign extension of the branch offset, or a skipped PC increment stays hidden until a later store or fetch exposes it. The value then shows on mem_wdata or mem_addr, usually within two or three instructions. For this reason the bench compares every strobe event, with its cycle, address and data, against an instruction-level model of the program.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

  // Opcode values held in the top field of the instruction word (R3)
  localparam int OP_ADDM  = 1;
  localparam int OP_LOAD  = 2;
  localparam int OP_STORE = 3;
  localparam int OP_BRA   = 4;

  // Bus source slots
  localparam int NSRC    = 5;
  localparam int SRC_PC  = 0;
  localparam int SRC_Z   = 1;
  localparam int SRC_MDR = 2;
  localparam int SRC_GPR = 3;
  localparam int SRC_OFF = 4;

  // One control word per step
  typedef struct packed {
    logic [NSRC-1:0] oe;        // bus out-enables, one per source
    logic            pc_in;
    logic            mar_in;
    logic            mdr_inp;   // MDR loads from the internal bus
    logic            mdr_inm;   // MDR loads from the memory read data
    logic            ir_in;
    logic            y_in;
    logic            z_in;
    logic            sel_y;     // ALU A input: 1 = Y, 0 = increment constant
    logic            gpr_in;    // register field A loads from the bus
    logic            gpr_src_b; // register read index: 1 = field B, 0 = field A
    logic            mem_rd;
    logic            mem_wr;
    logic            end_s;     // last step of the instruction
  } ctl_t;

endpackage

// File: rtl/sbus_step_ctl.sv
module sbus_step_ctl #(
  parameter  int NSTEP = 7,
  localparam int SW    = $clog2(NSTEP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             end_s,
  output logic [SW-1:0]    step,
  output logic [NSTEP-1:0] t_hot
);

  localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

  always_ff @(posedge clk) begin
    if (rst)               step <= '0;
    else if (end_s)        step <= '0;
    else if (step != LAST) step <= step + 1'b1;
  end

  // One-hot time slots: t_hot[k] is step k+1
  for (genvar k = 0; k < NSTEP; k++) begin : g_slot
    assign t_hot[k] = (step == SW'(k));
  end

endmodule

// File: rtl/sbus_ctl_enc.sv
module sbus_ctl_enc
  import sbus_pkg::*;
#(
  parameter  int OPW   = 4,
  parameter  int NSTEP = 7,
  localparam int OPN   = 2 ** OPW
) (
  input  logic [OPW-1:0]   opcode,
  input  logic [NSTEP-1:0] t,
  output logic [OPN-1:0]   op_hot,
  output ctl_t             cw
);

  localparam logic [OPN-1:0] KNOWN = (OPN'(1) << OP_ADDM) | (OPN'(1) << OP_LOAD) |
                                     (OPN'(1) << OP_STORE) | (OPN'(1) << OP_BRA);

  logic is_add, is_ld, is_st, is_br, is_other;

  // Instruction decoder: one line per opcode value
  always_comb begin
    op_hot = '0;
    op_hot[opcode] = 1'b1;
  end

  assign is_add   = op_hot[OP_ADDM];
  assign is_ld    = op_hot[OP_LOAD];
  assign is_st    = op_hot[OP_STORE];
  assign is_br    = op_hot[OP_BRA];
  assign is_other = |(op_hot & ~KNOWN);

  // Encoder: each control line is a sum of slot and slot-and-opcode products
  always_comb begin
    cw = '0;
    cw.oe[SRC_PC]  = t[0] | (t[3] & is_br);
    cw.oe[SRC_Z]   = t[1] | (t[6] & is_add) | (t[5] & is_br);
    cw.oe[SRC_MDR] = t[2] | (t[5] & (is_add | is_ld));
    cw.oe[SRC_GPR] = (t[3] & (is_add | is_ld | is_st)) | (t[4] & (is_add | is_st));
    cw.oe[SRC_OFF] = t[4] & is_br;
    cw.mar_in      = t[0] | (t[3] & (is_add | is_ld | is_st));
    cw.y_in        = t[0] | (t[4] & is_add) | (t[3] & is_br);
    cw.z_in        = t[0] | (t[5] & is_add) | (t[4] & is_br);
    cw.sel_y       = (t[5] & is_add) | (t[4] & is_br);
    cw.pc_in       = t[1] | (t[5] & is_br);
    cw.mem_rd      = t[1] | (t[4] & (is_add | is_ld));
    cw.mdr_inm     = t[1] | (t[4] & (is_add | is_ld));
    cw.ir_in       = t[2];
    cw.gpr_src_b   = t[3];
    cw.mdr_inp     = t[4] & is_st;
    cw.gpr_in      = (t[5] & is_ld) | (t[6] & is_add);
    cw.mem_wr      = t[5] & is_st;
    cw.end_s       = (t[3] & is_other) | (t[5] & (is_ld | is_st | is_br)) | (t[6] & is_add);
  end

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
  parameter  int DW   = 16,
  parameter  int NREG = 8,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = regs[raddr];

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
  parameter int DW  = 16,
  parameter int INC = 1
) (
  input  logic          sel_y,
  input  logic [DW-1:0] y,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum
);

  function automatic logic [DW-1:0] add_w(input logic [DW-1:0] a, input logic [DW-1:0] c);
    return a + c;
  endfunction

  logic [DW-1:0] a_op;

  assign a_op = sel_y ? y : DW'(INC);
  assign sum  = add_w(a_op, b);

endmodule

// File: rtl/sbus_core.sv
module sbus_core
  import sbus_pkg::*;
#(
  parameter  int DW    = 16,
  parameter  int NREG  = 8,
  parameter  int OPW   = 4,
  parameter  int OFFW  = 8,
  parameter  int INC   = 1,
  parameter  int NSTEP = 7,
  localparam int RW    = $clog2(NREG),
  localparam int SW    = $clog2(NSTEP),
  localparam int OPN   = 2 ** OPW
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rd,
  output logic          mem_wr
);

  function automatic logic [DW-1:0] sext_off(input logic [OFFW-1:0] f);
    return {{(DW-OFFW){f[OFFW-1]}}, f};
  endfunction

  logic [DW-1:0] pc, ir, mar, mdr, y, z;
  logic [DW-1:0] bus_w, gpr_rd, off_ext, alu_sum;
  logic [OPW-1:0] opcode;
  logic [RW-1:0]  fld_a, fld_b, gpr_raddr;
  ctl_t           cw;

  // Named internal events for the checker
  logic [NSRC-1:0]  bus_oe;
  logic             end_s;
  logic [SW-1:0]    step;
  logic [NSTEP-1:0] t_hot;
  logic [OPN-1:0]   op_hot;

  assign opcode  = ir[DW-1 -: OPW];
  assign fld_a   = ir[DW-OPW-1 -: RW];
  assign fld_b   = ir[DW-OPW-RW-1 -: RW];
  assign off_ext = sext_off(ir[OFFW-1:0]);
  assign bus_oe  = cw.oe;
  assign end_s   = cw.end_s;

  sbus_step_ctl #(.NSTEP(NSTEP)) u_step (
    .clk(clk), .rst(rst), .end_s(end_s), .step(step), .t_hot(t_hot)
  );

  sbus_ctl_enc #(.OPW(OPW), .NSTEP(NSTEP)) u_enc (
    .opcode(opcode), .t(t_hot), .op_hot(op_hot), .cw(cw)
  );

  assign gpr_raddr = cw.gpr_src_b ? fld_b : fld_a;

  sbus_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst), .we(cw.gpr_in), .waddr(fld_a), .wdata(bus_w),
    .raddr(gpr_raddr), .rdata(gpr_rd)
  );

  sbus_alu #(.DW(DW), .INC(INC)) u_alu (
    .sel_y(cw.sel_y), .y(y), .b(bus_w), .sum(alu_sum)
  );

  // Shared bus modelled as an AND-OR selector in place of tristate buffers
  always_comb begin
    bus_w = ({DW{bus_oe[SRC_PC]}}  & pc)
          | ({DW{bus_oe[SRC_Z]}}   & z)
          | ({DW{bus_oe[SRC_MDR]}} & mdr)
          | ({DW{bus_oe[SRC_GPR]}} & gpr_rd)
          | ({DW{bus_oe[SRC_OFF]}} & off_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      ir  <= '0;
      mar <= '0;
      mdr <= '0;
      y   <= '0;
      z   <= '0;
    end else begin
      if (cw.pc_in)        pc  <= bus_w;
      if (cw.ir_in)        ir  <= bus_w;
      if (cw.mar_in)       mar <= bus_w;
      if (cw.mdr_inm)      mdr <= mem_rdata;
      else if (cw.mdr_inp) mdr <= bus_w;
      if (cw.y_in)         y   <= bus_w;
      if (cw.z_in)         z   <= alu_sum;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = cw.mem_rd;
  assign mem_wr    = cw.mem_wr;

endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk #(
  parameter int DW   = 16,
  parameter int SW   = 3,
  parameter int NSRC = 5,
  parameter int OPN  = 16,
  parameter int INC  = 1
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] bus_oe,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            end_s,
  input logic [SW-1:0]   step,
  input logic [OPN-1:0]  op_hot,
  input logic [DW-1:0]   pc
);

  // R9
  bus_one_src_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(bus_oe));

  // R9
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));

  // R10
  end_restart_chk: assert property (@(posedge clk) disable iff (rst) end_s |=> (step == '0));

  // R10
  step_advance_chk: assert property (@(posedge clk) disable iff (rst)
    !end_s |=> (step == SW'($past(step) + 1'b1)));

  // R10
  op_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot(op_hot));

  // R2
  fetch_read_chk: assert property (@(posedge clk) disable iff (rst) (step == SW'(1)) |-> mem_rd);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step == SW'(1)) |=> (pc == DW'($past(pc) + DW'(INC))));

endmodule

bind sbus_core sbus_core_chk #(
  .DW(DW), .SW(SW), .NSRC(sbus_pkg::NSRC), .OPN(OPN), .INC(INC)
) i_chk (
  .clk(clk), .rst(rst), .bus_oe(bus_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .end_s(end_s), .step(step), .op_hot(op_hot), .pc(pc)
);

// File: tb/test_sbus_core.sv
module test_sbus_core;

  typedef struct {
    int          cyc;
    bit          wr;
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } ev_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr;

  logic [15:0] mem [256];
  ev_t         expq[$];
  int          cyc = 0;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  sbus_core i_sbus_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (!rst) cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input string detail);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s", tag, detail);
    end
  endtask

  task automatic push(input int c, input bit w, input logic [15:0] a,
                      input logic [15:0] d, input string tag);
    ev_t e;
    e.cyc = c; e.wr = w; e.addr = a; e.data = d; e.tag = tag;
    expq.push_back(e);
  endtask

  // Driver: instruction-level model of the program; fields per R3
  task automatic build_expect(input int n);
    logic [15:0] r [8];
    logic [15:0] mm [256];
    logic [15:0] pc, ins;
    logic [3:0]  op;
    logic [2:0]  fa, fb;
    int          start, len;
    string       prev;
    for (int k = 0; k < 8; k++) r[k] = '0;
    for (int k = 0; k < 256; k++) mm[k] = mem[k];
    pc = '0; start = 0; prev = "R1";
    for (int i = 0; i < n; i++) begin
      ins = mm[pc[7:0]];
      op  = ins[15:12];
      fa  = ins[11:9];
      fb  = ins[8:6];
      push(start + 1, 1'b0, pc, '0, {prev, " R2 R10 fetch"});
      pc = pc + 16'd1;
      case (op)
        4'd1: begin
          push(start + 4, 1'b0, r[fb], '0, "R4 operand read");
          r[fa] = r[fa] + mm[r[fb][7:0]];
          len = 7; prev = "R4";
        end
        4'd2: begin
          push(start + 4, 1'b0, r[fb], '0, "R5 load read");
          r[fa] = mm[r[fb][7:0]];
          len = 6; prev = "R5";
        end
        4'd3: begin
          push(start + 5, 1'b1, r[fb], r[fa], "R6 R3 store write");
          mm[r[fb][7:0]] = r[fa];
          len = 6; prev = "R6";
        end
        4'd4: begin
          pc = pc + {{8{ins[7]}}, ins[7:0]};
          len = 6; prev = "R7";
        end
        default: begin
          len = 4; prev = "R8";
        end
      endcase
      start += len;
    end
  endtask

  // Monitor: compare every strobe event against the expected queue
  always @(negedge clk) begin
    if (!rst && !finished && (mem_rd || mem_wr)) begin
      check(!(mem_rd && mem_wr), "R9", $sformatf("rd=%0b wr=%0b expected not both", mem_rd, mem_wr));
      if (expq.size() == 0) begin
        check(1'b0, "R2", $sformatf("unexpected strobe at cycle %0d addr %h", cyc, mem_addr));
      end else begin
        ev_t e;
        e = expq.pop_front();
        check((mem_wr == e.wr) && (cyc == e.cyc) && (mem_addr == e.addr) &&
              (!e.wr || mem_wdata == e.data), e.tag,
              $sformatf("got wr=%0b cyc=%0d addr=%h data=%h expected wr=%0b cyc=%0d addr=%h data=%h",
                        mem_wr, cyc, mem_addr, mem_wdata, e.wr, e.cyc, e.addr, e.data));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog", $sformatf("run hung, %0d events left expected 0", expq.size()));
    finish_run();
  end

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = '0;
    // Program; word = op[15:12] A[11:9] B[8:6], branch offset [7:0]
    mem[0]  = 16'h2430; // load r2 <- M[r0]; r2 = 0x2430 (word itself)
    mem[1]  = 16'h2680; // load r3 <- M[r2]
    mem[2]  = 16'h1680; // add  r3 <- r3 + M[r2]
    mem[3]  = 16'h3680; // store M[r2] <- r3
    mem[4]  = 16'h0FFF; // undefined opcode
    mem[5]  = 16'h1880; // add  r4 <- r4 + M[r2]
    mem[6]  = 16'h3800; // store M[r0] <- r4
    mem[7]  = 16'h4002; // branch +2 -> 10
    mem[8]  = 16'h3600; // skipped
    mem[9]  = 16'h3600; // skipped
    mem[10] = 16'h4003; // branch +3 -> 14
    mem[11] = 16'h3600; // skipped
    mem[12] = 16'h3400; // store M[r0] <- r2
    mem[13] = 16'h40FF; // branch -1 -> 13 (self loop)
    mem[14] = 16'h3480; // store M[r2] <- r2
    mem[15] = 16'h40FC; // branch -4 -> 12
    mem[8'h30] = 16'hF111; // add result wraps: 0xF111 + 0xF111 = 0xE222 (R4)
    build_expect(18);

    @(negedge clk);
    // R1: reset state at the ports
    check(mem_rd == 1'b0 && mem_wr == 1'b0 && mem_addr == '0 && mem_wdata == '0, "R1",
          $sformatf("rd=%0b wr=%0b addr=%h wdata=%h expected 0 0 0000 0000",
                    mem_rd, mem_wr, mem_addr, mem_wdata));
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;

    wait (expq.size() == 0);
    repeat (5) @(posedge clk);
    finish_run();
  end

endmodule